// File: doc/BRIEF.md
# Synchronized Three-Channel Delta-Sigma ADC Reader

This block sits in an FPGA and serves three delta-sigma converters that must sample in lockstep. It derives one master clock from the system clock and drives it to every converter. After reset it sends a single sync pulse from the same timebase, so all converters start their decimation at the same master-clock edge. From then on the converters run freely at their configured output rate.

Each converter signals a fresh result by pulling its active-low ready line low. When all ready lines are low and the combined line has just fallen, the block runs one shared serial clock. It shifts in a 32-bit two's-complement word from each converter in parallel, MSB first. The serial clock changes only on master-clock rising edges. Its period is a fixed, even number of master clocks, so every high and low phase lasts whole master-clock periods and covers the converter's output delay after a falling edge. When the last bit is in, the three words and the three over-range flags are presented together with a one-cycle valid strobe for a downstream packetizer. A ready fall that arrives while a transfer is running sets a sticky overrun flag.

Top module: `adc_sync_reader`

## Requirements
- R1: `mclk_o` toggles every `MCLK_HALF` system clocks from the release of reset onward, giving a master-clock period of 2*`MCLK_HALF` system clocks.
- R2: After reset `sync_o` goes high exactly once. Its rising edge coincides with a rising edge of `mclk_o`, it stays high for `SYNC_MCLKS` master-clock periods, and it never rises again until the next reset.
- R3: Ready-line falls that occur before the sync pulse has ended start no transfer. A low level held across the end of the sync pulse starts none either. Only a later high-to-low transition of the combined ready line does.
- R4: In idle, a fall of the combined ready line (high while any channel's `drdy_n_i` is high, low once all are low) starts one transfer of exactly 32 `sclk_o` rising edges. A fall during a transfer starts no extra transfer.
- R5: `sclk_o` is low outside transfers and changes only on `mclk_o` rising edges. During a transfer its high phase lasts `SCLK_MULT`/2 master-clock periods. Each low phase before a rising edge lasts at least that long. `SCLK_MULT` must be even and in 2..16.
- R6: `dout_i[c]` is sampled at each `sclk_o` rising edge. The first sample is bit 31 (sign) of channel c's word and the last is bit 0. The finished word appears on `data_o[c*32+31 : c*32]`.
- R7: `ovr_o[c]` carries channel c's over-range input (1 = over range, 0 = normal), captured when that transfer completes.
- R8: `valid_o` is high for exactly one system clock per completed transfer. `data_o` and `ovr_o` change only in that cycle and hold their values between strobes.
- R9: A fall of the combined ready line during a transfer sets `overrun_o` to 1. It stays 1 until reset, and the interrupted transfer still delivers correct data.
- R10: `din_o` stays 0 at all times, because the block issues no commands.
- R11: A transfer ends within (33 * `SCLK_MULT` * 2 * `MCLK_HALF`) system clocks of its start. This is far shorter than the 64 conversion periods after which the converter's serial port would reset itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| drdy_n_i | input | NCH | Per-converter active-low ready lines |
| dout_i | input | NCH | Per-converter serial data |
| ovr_i | input | NCH | Per-converter over-range flags |
| mclk_o | output | 1 | Shared master clock |
| sync_o | output | 1 | Shared single sync pulse |
| sclk_o | output | 1 | Shared serial clock |
| din_o | output | 1 | Serial command data, held low |
| data_o | output | NCH*WBITS | Captured words, channel c in slice c |
| ovr_o | output | NCH | Captured over-range flags |
| valid_o | output | 1 | One-cycle strobe for new results |
| overrun_o | output | 1 | Sticky flag for a ready fall during a transfer |

## Verification
The hardest situations to reach are a ready fall that lands inside a running transfer and a ready fall that lands before the sync pulse has ended. Both depend on how the ready edges are placed against the block's own internal progress. The bench pulls the ready lines low while the block is still counting toward its sync pulse and holds them low past the end of the pulse, so no transfer should follow. For the overrun case, the bench watches the serial clock at the ports, releases and re-asserts the ready lines after the fifth rising edge, and then confirms that the flag sticks and that the data is still correct.

// File: rtl/adc_sync_reader.sv
module adc_sync_reader #(
  parameter int NCH        = 3,
  parameter int WBITS      = 32,
  parameter int MCLK_HALF  = 12,
  parameter int SCLK_MULT  = 4,
  parameter int BOOT_MCLKS = 16,
  parameter int SYNC_MCLKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       drdy_n_i,
  input  logic [NCH-1:0]       dout_i,
  input  logic [NCH-1:0]       ovr_i,
  output logic                 mclk_o,
  output logic                 sync_o,
  output logic                 sclk_o,
  output logic                 din_o,
  output logic [NCH*WBITS-1:0] data_o,
  output logic [NCH-1:0]       ovr_o,
  output logic                 valid_o,
  output logic                 overrun_o
);
  localparam int SCLK_HALF  = SCLK_MULT / 2;
  localparam int DW         = $clog2(MCLK_HALF + 1);
  localparam int PW         = $clog2(SCLK_MULT + 1);
  localparam int BW         = $clog2(WBITS + 1);
  localparam int TMAX       = (BOOT_MCLKS > SYNC_MCLKS) ? BOOT_MCLKS : SYNC_MCLKS;
  localparam int TW         = $clog2(TMAX + 1);
  localparam int XFER_LIMIT = (WBITS + 1) * SCLK_MULT * 2 * MCLK_HALF;
  localparam int XW         = $clog2(XFER_LIMIT + 2);

  typedef enum logic [1:0] {ST_BOOT, ST_SYNC, ST_IDLE, ST_XFER} st_t;

  st_t                       st;
  logic [DW-1:0]             mdiv;
  logic [TW-1:0]             tcnt;
  logic [PW-1:0]             ph;
  logic [BW-1:0]             nbit;
  logic [NCH-1:0]            rdy_m, rdy_s, ovr_m, ovr_s;
  logic                      rdy_prev;
  logic [NCH-1:0][WBITS-1:0] sh;
  logic                      mtick, rdy_fall, rise_ph, last_ph, sample_en;

  assign din_o     = 1'b0;
  assign mtick     = (mdiv == DW'(MCLK_HALF - 1)) && !mclk_o;
  assign rdy_fall  = rdy_prev && !(|rdy_s);
  assign rise_ph   = (ph == PW'(SCLK_HALF - 1));
  assign last_ph   = (ph == PW'(SCLK_MULT - 1));
  assign sample_en = (st == ST_XFER) && mtick && rise_ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdiv   <= '0;
      mclk_o <= 1'b0;
    end else if (mdiv == DW'(MCLK_HALF - 1)) begin
      mdiv   <= '0;
      mclk_o <= ~mclk_o;
    end else begin
      mdiv <= mdiv + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_m    <= '1;
      rdy_s    <= '1;
      rdy_prev <= 1'b1;
      ovr_m    <= '0;
      ovr_s    <= '0;
    end else begin
      rdy_m    <= drdy_n_i;
      rdy_s    <= rdy_m;
      rdy_prev <= |rdy_s;
      ovr_m    <= ovr_i;
      ovr_s    <= ovr_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0;
    end else if (sample_en) begin
      for (int c = 0; c < NCH; c++) sh[c] <= {sh[c][WBITS-2:0], dout_i[c]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_BOOT;
      tcnt      <= '0;
      ph        <= '0;
      nbit      <= '0;
      sync_o    <= 1'b0;
      sclk_o    <= 1'b0;
      valid_o   <= 1'b0;
      overrun_o <= 1'b0;
      data_o    <= '0;
      ovr_o     <= '0;
    end else begin
      valid_o <= 1'b0;
      case (st)
        ST_BOOT: if (mtick) begin
          if (tcnt == TW'(BOOT_MCLKS - 1)) begin
            tcnt   <= '0;
            sync_o <= 1'b1;
            st     <= ST_SYNC;
          end else begin
            tcnt <= tcnt + TW'(1);
          end
        end
        ST_SYNC: if (mtick) begin
          if (tcnt == TW'(SYNC_MCLKS - 1)) begin
            sync_o <= 1'b0;
            st     <= ST_IDLE;
          end else begin
            tcnt <= tcnt + TW'(1);
          end
        end
        ST_IDLE: if (rdy_fall) begin
          ph   <= PW'(SCLK_MULT - 1);
          nbit <= '0;
          st   <= ST_XFER;
        end
        ST_XFER: begin
          if (rdy_fall) overrun_o <= 1'b1;
          if (mtick) begin
            if (last_ph) begin
              ph     <= '0;
              sclk_o <= 1'b0;
              if (nbit == BW'(WBITS)) begin
                st      <= ST_IDLE;
                valid_o <= 1'b1;
                data_o  <= sh;
                ovr_o   <= ovr_s;
              end
            end else if (rise_ph) begin
              ph     <= ph + PW'(1);
              sclk_o <= 1'b1;
              nbit   <= nbit + BW'(1);
            end else begin
              ph <= ph + PW'(1);
            end
          end
        end
        default: st <= ST_BOOT;
      endcase
    end
  end

  logic [XW-1:0] xcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              xcnt <= '0;
    else if (st != ST_XFER)                  xcnt <= '0;
    else if (xcnt != XW'(XFER_LIMIT + 1))    xcnt <= xcnt + XW'(1);
  end

  p_sync_on_mclk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_o) |-> $rose(mclk_o));
  p_sync_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE || st == ST_XFER) |-> !sync_o);
  p_sclk_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_XFER) |-> !sclk_o);
  p_sclk_on_mclk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk_o) |-> $rose(mclk_o));
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(data_o) && $stable(ovr_o)));
  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);
  p_xfer_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xcnt <= XW'(XFER_LIMIT));
endmodule

// File: tb/tb_adc_sync_reader.sv
module tb_adc_sync_reader;
  localparam int NCH = 3, WBITS = 32, MCLK_HALF = 2, SCLK_MULT = 2;
  localparam int BOOT_MCLKS = 3, SYNC_MCLKS = 4;
  localparam int SW = (SCLK_MULT / 2) * 2 * MCLK_HALF;
  localparam int SYNC_W = SYNC_MCLKS * 2 * MCLK_HALF;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] drdy_n = '1, dout_i = '0, ovr_in = '0;
  logic mclk_o, sync_o, sclk_o, din_o, valid_o, overrun_o;
  logic [NCH*WBITS-1:0] data_o;
  logic [NCH-1:0] ovr_o;

  adc_sync_reader #(.NCH(NCH), .WBITS(WBITS), .MCLK_HALF(MCLK_HALF), .SCLK_MULT(SCLK_MULT),
    .BOOT_MCLKS(BOOT_MCLKS), .SYNC_MCLKS(SYNC_MCLKS)) dut (
    .clk(clk), .rst_n(rst_n), .drdy_n_i(drdy_n), .dout_i(dout_i), .ovr_i(ovr_in),
    .mclk_o(mclk_o), .sync_o(sync_o), .sclk_o(sclk_o), .din_o(din_o), .data_o(data_o),
    .ovr_o(ovr_o), .valid_o(valid_o), .overrun_o(overrun_o));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [WBITS-1:0] word [NCH];
  int bitp = 0;
  always @(negedge sclk_o) if (bitp > 0) begin
    bitp--;
    for (int c = 0; c < NCH; c++) dout_i[c] = word[c][bitp];
  end

  int mclk_run = 0, mclk_bad = 0, mclk_tog = 0;
  int sync_rises = 0, sync_falls = 0, sync_w = 0, sync_mclk_bad = 0;
  int sclk_rises = 0, sclk_bad = 0, sclk_run = 0;
  int din_hi = 0, valid_bad = 0;
  bit mclk_q = 0, sync_q = 0, sclk_q = 0, valid_q = 0;
  always @(negedge clk) if (rst_n) begin
    if (mclk_o != mclk_q) begin
      if (mclk_tog > 0 && mclk_run != MCLK_HALF) mclk_bad++;
      mclk_tog++;
      mclk_run = 1;
    end else mclk_run++;
    if (sync_o && !sync_q) begin
      sync_rises++;
      if (!mclk_o || mclk_run != 1) sync_mclk_bad++;
    end
    if (!sync_o && sync_q) sync_falls++;
    if (sync_o) sync_w++;
    if (sclk_o != sclk_q) begin
      if (sclk_o) begin
        sclk_rises++;
        if (sclk_run < SW) sclk_bad++;
      end else if (sclk_run != SW) sclk_bad++;
      if (!mclk_o || mclk_run != 1) sclk_bad++;
      sclk_run = 1;
    end else sclk_run++;
    if (din_o) din_hi++;
    if (valid_o && valid_q) valid_bad++;
    mclk_q = mclk_o; sync_q = sync_o; sclk_q = sclk_o; valid_q = valid_o;
  end

  task automatic wait_cycles_until_valid(output bit got);
    int n = 0;
    while (!valid_o && n < 5000) begin
      @(negedge clk);
      n++;
    end
    got = valid_o;
  endtask

  task automatic run_xfer(input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2,
                          input logic [2:0] ov, input bit glitch, input bit exp_ovf);
    logic [95:0] exp;
    bit got;
    drdy_n = '1;
    word[0] = w0; word[1] = w1; word[2] = w2;
    exp = {w2, w1, w0};
    bitp = WBITS - 1;
    for (int c = 0; c < NCH; c++) dout_i[c] = word[c][WBITS-1];
    ovr_in = ov;
    repeat (6) @(negedge clk);
    sclk_rises = 0; sclk_bad = 0;
    drdy_n = '0;
    if (glitch) begin
      for (int n = 0; n < 2000 && sclk_rises < 5; n++) @(negedge clk);
      drdy_n = '1;
      repeat (3) @(negedge clk);
      drdy_n = '0;
    end
    wait_cycles_until_valid(got);
    chk(got, "R4 valid strobe seen", 96'(got), 96'(1));
    chk(data_o == exp, "R6 words MSB first per channel", data_o, exp);
    chk(ovr_o == ov, "R7 over-range capture", 96'(ovr_o), 96'(ov));
    chk(sclk_rises == 32, "R4 sclk rising edges per transfer", 96'(sclk_rises), 96'(32));
    chk(sclk_bad == 0, "R5 sclk phase widths", 96'(sclk_bad), 96'(0));
    chk(overrun_o == exp_ovf, "R9 overrun flag", 96'(overrun_o), 96'(exp_ovf));
    @(negedge clk);
    chk(!valid_o, "R8 valid one cycle wide", 96'(valid_o), 96'(0));
    repeat (20) @(negedge clk);
    chk(!sclk_o && sclk_rises == 32, "R5 sclk idle low, no extra transfer R4", 96'(sclk_rises), 96'(32));
    chk(data_o == exp && ovr_o == ov, "R8 outputs held", data_o, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!sclk_o && !sync_o && !valid_o && !overrun_o && !mclk_o, "R5 reset outputs low",
        96'({sclk_o, sync_o, valid_o, overrun_o, mclk_o}), 96'(0));
    chk(data_o == '0 && ovr_o == '0, "R8 reset data clear", data_o, 96'(0));
    rst_n = 1;
    @(negedge clk);
    drdy_n = '0;
    for (int n = 0; n < 2000 && sync_falls == 0; n++) @(negedge clk);
    repeat (60) @(negedge clk);
    chk(sclk_rises == 0 && !valid_o, "R3 early ready fall ignored", 96'(sclk_rises), 96'(0));
    chk(sync_rises == 1, "R2 one sync pulse", 96'(sync_rises), 96'(1));
    chk(sync_w == SYNC_W, "R2 sync width", 96'(sync_w), 96'(SYNC_W));
    chk(sync_mclk_bad == 0, "R2 sync on mclk rise", 96'(sync_mclk_bad), 96'(0));

    run_xfer(32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 3'b000, 0, 0);
    run_xfer(32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0001, 3'b101, 0, 0);
    for (int i = 0; i < WBITS; i++)
      run_xfer(32'h1 << i, ~(32'h1 << i), 32'hA5A5_A5A5 ^ (32'(i) * 32'h0101_0101),
               3'(i % 8), 0, 0);
    run_xfer(32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_F0F0, 3'b111, 1, 1);
    run_xfer(32'hDEAD_BEEF, 32'h0000_FFFF, 32'hFFFF_0000, 3'b010, 0, 1);

    chk(sync_rises == 1, "R2 no later sync", 96'(sync_rises), 96'(1));
    chk(mclk_bad == 0 && mclk_tog > 100, "R1 master clock half period", 96'(mclk_bad), 96'(0));
    chk(din_hi == 0, "R10 din held low", 96'(din_hi), 96'(0));
    chk(valid_bad == 0, "R8 valid never two cycles", 96'(valid_bad), 96'(0));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule